// File: doc/BRIEF.md
# Microcode Patch Redirect Sequencer

This block drives the fetch side of a microcode sequencer. A microcode instruction pointer walks a fixed, parity-protected microcode ROM. A small bank of programmable breakpoint pairs sits beside the pointer. Each pair holds an arm bit, an address to watch for and an address to jump to. Whenever the pointer lands on a watched address, the block spends one cycle reloading the pointer from the paired jump address instead of issuing a micro-op. Jump addresses in the upper part of the address space select a writable patch memory. Patched micro-ops can branch back into the ROM, so a faulty ROM routine can be replaced, or skipped entirely, without changing the silicon.

The consumer of the micro-op stream drives `seq_branch` and `seq_target` in the same cycle as an issued micro-op to pick the next address. `seq_restart` re-enters the reset routine and keeps the breakpoint pairs and the patch contents. An armed pair on the reset entry address can therefore bypass that routine. The sequencer is a three-state machine. BOOT is the state after reset or a restart and issues nothing. FETCH issues the word at the pointer, or takes a redirect when the pointer is watched. REDIRECT issues the word at the jump target. The transitions are BOOT→FETCH (always), FETCH→FETCH (no hit), FETCH→REDIRECT (hit), REDIRECT→FETCH (always) and any state→BOOT (restart).

Top module: `ucode_patch_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `uop_valid` is 0. The first issued micro-op is at address 0. All pairs are disarmed and every patch word reads 0, so no redirection occurs until a pair is armed.
- R2: When a micro-op issues without a branch, the next issued address is the current address plus one, wrapping from 1023 to 0.
- R3: When `seq_branch` is 1 in a cycle that issues a micro-op, the next issued address is `seq_target`.
- R4: When the pointer equals the watch address of an armed pair during FETCH, that cycle issues nothing. The very next cycle issues the word at that pair's jump address, so a redirect costs exactly one cycle.
- R5: If several armed pairs watch the same address, the lowest-numbered pair supplies the jump address.
- R6: The word at a redirect target is issued without being compared against the pairs. A later sequential or branched arrival at the same address is compared as usual.
- R7: Addresses 0 to 959 read the ROM, whose word at address A is (A × 0x9E3779B1) mod 2^32. Addresses 960 to 1019 read patch word A−960, and addresses 1020 to 1023 read 0.
- R8: `uop_par_err` is 1 exactly when an issued ROM word fails its even-parity check. The ROM word at address 21 is stored with a defective parity bit. Patch words never raise the flag.
- R9: Configuration writes use `cfg_addr` bit 6 = 0 for pairs, with bits 5:1 as the pair index and bit 0 selecting watch (0) or jump (1). For a watch write, `cfg_wdata[9:0]` is the address and `cfg_wdata[10]` is the arm bit. For a jump write, `cfg_wdata[9:0]` is the jump address. Writing arm = 0 disarms the pair. A write takes effect from the next fetch onward.
- R10: A `seq_restart` pulse produces one idle cycle and then a fetch at address 0, with pairs and patch contents kept. An armed pair watching address 0 therefore skips the reset routine.
- R11: Patch writes use `cfg_addr` bit 6 = 1 with bits 5:0 as the word index. Patch writes to index 60 or above, and pair writes to index 4 or above, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration target: pair register or patch word |
| cfg_wdata | input | 32 | Configuration write data |
| seq_restart | input | 1 | Re-enter the reset routine at address 0 |
| seq_branch | input | 1 | Take `seq_target` after the micro-op issued this cycle |
| seq_target | input | 10 | Branch address |
| uop_valid | output | 1 | A micro-op issues this cycle |
| uop_addr | output | 10 | Microcode instruction pointer |
| uop_data | output | 32 | Issued micro-op word |
| uop_par_err | output | 1 | Parity failure on the issued ROM word |

## Verification
The hardest case to reach is a jump target that is itself a watched address. It only shows up when two pairs are chained and the pointer reaches the second watch address twice: once through a redirect, where no compare must happen, and once through an ordinary branch, where the compare must happen. The bench arms pair 2 to jump to 962 and pair 3 to watch 962. It first enters 962 through the redirect and expects no idle cycle. It then branches back to 962 from 963 and expects the idle cycle followed by the second jump. A write that lands exactly one fetch ahead of the pointer is reached by issuing the write in the same cycle that the preceding address issues.

// File: rtl/ucp_pkg.sv
package ucp_pkg;

    // Sequencer states: idle entry, normal fetch, issue at redirect target
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REDIR = 2'd2
    } seq_state_e;

    // Even parity over a data word plus its stored check bit: 1 means failure
    function automatic logic parity_fail(input logic chk, input logic [63:0] word);
        return chk ^ (^word);
    endfunction

endpackage

// File: rtl/ucp_match_bank.sv
module ucp_match_bank #(
    parameter int NPAIRS = 4,
    parameter int UA_W   = 10,
    parameter int IDX_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_jump_sel,
    input  logic [UA_W-1:0]      wr_addr,
    input  logic                 wr_arm,
    input  logic [UA_W-1:0]      probe,
    output logic [NPAIRS-1:0]    hit_sel,
    output logic [UA_W-1:0]      hit_dest
);

    logic [NPAIRS-1:0]           arm_q;
    logic [NPAIRS-1:0][UA_W-1:0] watch_q;
    logic [NPAIRS-1:0][UA_W-1:0] jump_q;
    logic [NPAIRS-1:0]           raw_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q   <= '0;
            watch_q <= '0;
            jump_q  <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NPAIRS; p++) begin
                if (wr_idx == IDX_W'(p)) begin
                    if (wr_jump_sel) begin
                        jump_q[p] <= wr_addr;
                    end else begin
                        watch_q[p] <= wr_addr;
                        arm_q[p]   <= wr_arm;
                    end
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NPAIRS; g++) begin : g_cmp
            assign raw_hit[g] = arm_q[g] && (watch_q[g] == probe);
        end
    endgenerate

    // Scan from the top so that the lowest-numbered hit is written last
    always_comb begin
        hit_sel  = '0;
        hit_dest = '0;
        for (int i = NPAIRS - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                hit_sel    = '0;
                hit_sel[i] = 1'b1;
                hit_dest   = jump_q[i];
            end
        end
    end

endmodule

// File: rtl/ucp_patch_ram.sv
module ucp_patch_ram #(
    parameter int WORDS = 60,
    parameter int DW    = 32,
    parameter int WA_W  = 6,
    parameter int RA_W  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [WA_W-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [RA_W-1:0] raddr,
    output logic [DW-1:0]   rdata
);

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) mem_q[k] <= '0;
        end else if (we && (32'(waddr) < WORDS)) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (raddr == RA_W'(k)) rdata = mem_q[k];
        end
    end

endmodule

// File: rtl/ucp_rom.sv
module ucp_rom #(
    parameter int              UA_W      = 10,
    parameter int              DW        = 32,
    parameter logic [DW-1:0]   SEED      = 32'h9E37_79B1,
    parameter int              FLAW_ADDR = 21
) (
    input  logic [UA_W-1:0] addr,
    output logic [DW-1:0]   data,
    output logic            par_fail
);

    logic [DW-1:0] word;
    logic          stored_par;

    // Contents are computed from the address; one word holds a bad check bit
    always_comb begin
        word       = DW'(addr) * SEED;
        stored_par = (^word) ^ (addr == UA_W'(FLAW_ADDR));
        data       = word;
        par_fail   = ucp_pkg::parity_fail(stored_par, 64'(word));
    end

endmodule

// File: rtl/ucode_patch_seq.sv
module ucode_patch_seq #(
    parameter int                UA_W        = 10,
    parameter int                UOP_W       = 32,
    parameter int                NPAIRS      = 4,
    parameter int                PATCH_BASE  = 960,
    parameter int                PATCH_WORDS = 60,
    parameter int                RESET_VEC   = 0,
    parameter int                FLAW_ADDR   = 21,
    parameter logic [UOP_W-1:0]  ROM_SEED    = 32'h9E37_79B1,
    localparam int               PW_AW       = $clog2(PATCH_WORDS),
    localparam int               PAIR_AW     = $clog2(NPAIRS),
    localparam int               CFG_IDX_W   = (PW_AW > PAIR_AW + 1) ? PW_AW : PAIR_AW + 1,
    localparam int               CFG_AW      = CFG_IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [UOP_W-1:0]  cfg_wdata,
    input  logic              seq_restart,
    input  logic              seq_branch,
    input  logic [UA_W-1:0]   seq_target,
    output logic              uop_valid,
    output logic [UA_W-1:0]   uop_addr,
    output logic [UOP_W-1:0]  uop_data,
    output logic              uop_par_err
);
    import ucp_pkg::*;

    seq_state_e         state_q, state_d;
    logic [UA_W-1:0]    uip_q, uip_d;
    logic [NPAIRS-1:0]  hit_sel;
    logic [UA_W-1:0]    hit_dest;
    logic               hit;
    logic               in_patch;
    logic [UA_W-1:0]    patch_off;
    logic [UOP_W-1:0]   patch_rd, rom_rd;
    logic               rom_bad;
    logic               issue;

    // Configuration decode
    logic cfg_patch;
    assign cfg_patch = cfg_addr[CFG_AW-1];

    ucp_match_bank #(
        .NPAIRS (NPAIRS),
        .UA_W   (UA_W),
        .IDX_W  (CFG_IDX_W - 1)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we && !cfg_patch),
        .wr_idx      (cfg_addr[CFG_IDX_W-1:1]),
        .wr_jump_sel (cfg_addr[0]),
        .wr_addr     (cfg_wdata[UA_W-1:0]),
        .wr_arm      (cfg_wdata[UA_W]),
        .probe       (uip_q),
        .hit_sel     (hit_sel),
        .hit_dest    (hit_dest)
    );

    assign hit       = |hit_sel;
    assign in_patch  = (uip_q >= UA_W'(PATCH_BASE));
    assign patch_off = uip_q - UA_W'(PATCH_BASE);

    ucp_patch_ram #(
        .WORDS (PATCH_WORDS),
        .DW    (UOP_W),
        .WA_W  (CFG_IDX_W),
        .RA_W  (UA_W)
    ) u_patch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we && cfg_patch),
        .waddr (cfg_addr[CFG_IDX_W-1:0]),
        .wdata (cfg_wdata),
        .raddr (patch_off),
        .rdata (patch_rd)
    );

    ucp_rom #(
        .UA_W      (UA_W),
        .DW        (UOP_W),
        .SEED      (ROM_SEED),
        .FLAW_ADDR (FLAW_ADDR)
    ) u_rom (
        .addr     (uip_q),
        .data     (rom_rd),
        .par_fail (rom_bad)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            uip_q   <= UA_W'(RESET_VEC);
        end else begin
            state_q <= state_d;
            uip_q   <= uip_d;
        end
    end

    // Next state and pointer
    always_comb begin
        state_d = state_q;
        uip_d   = uip_q;
        if (seq_restart) begin
            state_d = ST_BOOT;
            uip_d   = UA_W'(RESET_VEC);
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    state_d = ST_FETCH;
                end
                ST_FETCH: begin
                    if (hit) begin
                        state_d = ST_REDIR;
                        uip_d   = hit_dest;
                    end else begin
                        uip_d = seq_branch ? seq_target : uip_q + 1'b1;
                    end
                end
                ST_REDIR: begin
                    state_d = ST_FETCH;
                    uip_d   = seq_branch ? seq_target : uip_q + 1'b1;
                end
                default: begin
                    state_d = ST_BOOT;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        issue       = (state_q == ST_REDIR) || ((state_q == ST_FETCH) && !hit);
        uop_valid   = issue;
        uop_addr    = uip_q;
        uop_data    = '0;
        uop_par_err = 1'b0;
        if (issue) begin
            uop_data    = in_patch ? patch_rd : rom_rd;
            uop_par_err = !in_patch && rom_bad;
        end
    end

endmodule

// File: rtl/ucp_seq_checks.sv
module ucp_seq_checks #(
    parameter int UA_W       = 10,
    parameter int NPAIRS     = 4,
    parameter int PATCH_BASE = 960
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_restart,
    input  logic                seq_branch,
    input  logic [UA_W-1:0]     seq_target,
    input  logic                uop_valid,
    input  logic [UA_W-1:0]     uop_addr,
    input  logic                uop_par_err,
    input  ucp_pkg::seq_state_e state_q,
    input  logic [NPAIRS-1:0]   hit_sel,
    input  logic [UA_W-1:0]     hit_dest
);
    import ucp_pkg::*;

    p_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !seq_restart && !seq_branch) |=>
            (!uop_valid || uop_addr == $past(uop_addr) + 1'b1));

    p_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !seq_restart && seq_branch) |=>
            (!uop_valid || uop_addr == $past(seq_target)));

    p_hit_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && hit_sel != '0) |-> !uop_valid);

    p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && hit_sel != '0 && !seq_restart) |=>
            (uop_valid && uop_addr == $past(hit_dest)));

    p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_sel));

    p_parity_rom_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uop_par_err |-> (uop_valid && uop_addr < UA_W'(PATCH_BASE)));

    p_restart_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_restart |=> !uop_valid);

endmodule

bind ucode_patch_seq ucp_seq_checks #(
    .UA_W       (UA_W),
    .NPAIRS     (NPAIRS),
    .PATCH_BASE (PATCH_BASE)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_restart (seq_restart),
    .seq_branch  (seq_branch),
    .seq_target  (seq_target),
    .uop_valid   (uop_valid),
    .uop_addr    (uop_addr),
    .uop_par_err (uop_par_err),
    .state_q     (state_q),
    .hit_sel     (hit_sel),
    .hit_dest    (hit_dest)
);

// File: tb/ucode_patch_seq_test.sv
module ucode_patch_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        seq_restart = 1'b0;
    logic        seq_branch = 1'b0;
    logic [9:0]  seq_target = '0;
    logic        uop_valid;
    logic [9:0]  uop_addr;
    logic [31:0] uop_data;
    logic        uop_par_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] shadow [60];

    always #2 clk = ~clk;

    ucode_patch_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .seq_restart (seq_restart),
        .seq_branch  (seq_branch),
        .seq_target  (seq_target),
        .uop_valid   (uop_valid),
        .uop_addr    (uop_addr),
        .uop_data    (uop_data),
        .uop_par_err (uop_par_err)
    );

    function automatic logic [31:0] exp_word(input int a);
        if (a < 960) return 32'(a) * 32'h9E37_79B1;
        if (a < 1020) return shadow[a - 960];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: sample away from the edge, then drive branch inputs
    task automatic cyc(input bit ev, input int ea, input bit br, input int tgt,
                       input string req);
        @(negedge clk);
        chk(uop_valid == ev, req, "valid", 32'(uop_valid), 32'(ev));
        if (ev) begin
            chk(uop_addr == 10'(ea), req, "addr", 32'(uop_addr), 32'(ea));
            chk(uop_data == exp_word(ea), req, "data", uop_data, exp_word(ea));
            chk(uop_par_err == (ea == 21), req, "parity", 32'(uop_par_err), 32'(ea == 21));
        end
        seq_branch = br;
        seq_target = 10'(tgt);
    endtask

    task automatic cfg_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        seq_branch = 1'b0;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [6:0] pair_reg(input int idx, input bit jump);
        return {1'b0, 5'(idx), jump};
    endfunction

    function automatic logic [31:0] watch_val(input bit arm, input int a);
        return {21'd0, arm, 10'(a)};
    endfunction

    task automatic patch_wr(input int idx, input logic [31:0] d);
        cfg_wr({1'b1, 6'(idx)}, d);
        if (idx < 60) shadow[idx] = d;
    endtask

    task automatic restart(input string req);
        @(negedge clk);
        seq_branch = 1'b0;
        seq_restart = 1'b1;
        @(negedge clk);
        seq_restart = 1'b0;
        chk(uop_valid == 1'b0, req, "restart idle", 32'(uop_valid), 32'h0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(uop_valid == 1'b0, "R1", "valid in reset", 32'(uop_valid), 32'h0);
        rst_n = 1'b1;
        chk(uop_valid == 1'b0, "R1", "valid after release", 32'(uop_valid), 32'h0);
        cyc(1, 0, 0, 0, "R1");
        cyc(1, 1, 0, 0, "R2");
        cyc(1, 2, 0, 0, "R2");
        cyc(1, 3, 0, 0, "R2");
    endtask

    task automatic t_branch_wrap;
        cyc(1, 4, 1, 1023, "R3");
        cyc(1, 1023, 0, 0, "R7");
        cyc(1, 0, 0, 0, "R2 wrap");
        cyc(1, 1, 1, 100, "R3");
        cyc(1, 100, 0, 0, "R3");
    endtask

    task automatic t_redirect;
        patch_wr(0, 32'h0000_0001);
        patch_wr(1, 32'hC0DE_1111);
        cfg_wr(pair_reg(1, 1), 32'(960));
        cfg_wr(pair_reg(1, 0), watch_val(1, 5));
        restart("R10");
        for (int a = 0; a < 5; a++) cyc(1, a, 0, 0, "R4");
        cyc(0, 0, 0, 0, "R4 bubble");
        cyc(1, 960, 0, 0, "R4");
        cyc(1, 961, 1, 6, "R7");
        cyc(1, 6, 0, 0, "R7 back to rom");
    endtask

    task automatic t_priority;
        patch_wr(10, 32'hAAAA_0010);
        patch_wr(20, 32'hBBBB_0020);
        cfg_wr(pair_reg(0, 1), 32'(970));
        cfg_wr(pair_reg(0, 0), watch_val(1, 2));
        cfg_wr(pair_reg(2, 1), 32'(980));
        cfg_wr(pair_reg(2, 0), watch_val(1, 2));
        restart("R10");
        cyc(1, 0, 0, 0, "R5");
        cyc(1, 1, 0, 0, "R5");
        cyc(0, 0, 0, 0, "R5 bubble");
        cyc(1, 970, 0, 0, "R5 lowest pair");
        cfg_wr(pair_reg(0, 0), watch_val(0, 2));
        restart("R10");
        cyc(1, 0, 0, 0, "R9");
        cyc(1, 1, 0, 0, "R9");
        cyc(0, 0, 0, 0, "R9 bubble");
        cyc(1, 980, 0, 0, "R9 disarmed pair yields");
    endtask

    task automatic t_no_recheck;
        patch_wr(2, 32'h1234_0962);
        patch_wr(3, 32'h1234_0963);
        patch_wr(30, 32'h5678_0990);
        cfg_wr(pair_reg(3, 1), 32'(990));
        cfg_wr(pair_reg(3, 0), watch_val(1, 962));
        cfg_wr(pair_reg(2, 1), 32'(962));
        restart("R10");
        cyc(1, 0, 0, 0, "R6");
        cyc(1, 1, 0, 0, "R6");
        cyc(0, 0, 0, 0, "R6 bubble");
        cyc(1, 962, 0, 0, "R6 target not rechecked");
        cyc(1, 963, 1, 962, "R6");
        cyc(0, 0, 0, 0, "R6 branch arrival compared");
        cyc(1, 990, 0, 0, "R6");
    endtask

    task automatic t_parity;
        cfg_wr(pair_reg(1, 0), watch_val(0, 5));
        cfg_wr(pair_reg(2, 0), watch_val(0, 2));
        cfg_wr(pair_reg(3, 0), watch_val(0, 962));
        restart("R10");
        cyc(1, 0, 1, 20, "R8");
        cyc(1, 20, 0, 0, "R8");
        cyc(1, 21, 0, 0, "R8 flawed word");
        cyc(1, 22, 1, 960, "R8");
        cyc(1, 960, 0, 0, "R8 patch odd weight");
    endtask

    task automatic t_timing;
        restart("R10");
        cyc(1, 0, 0, 0, "R9");
        cyc(1, 1, 0, 0, "R9");
        cfg_we = 1'b1; cfg_addr = pair_reg(0, 1); cfg_wdata = 32'(40);
        cyc(1, 2, 0, 0, "R9");
        cfg_addr = pair_reg(0, 0); cfg_wdata = watch_val(1, 3);
        cyc(0, 0, 0, 0, "R9 write seen at next fetch");
        cfg_we = 1'b0;
        cyc(1, 40, 0, 0, "R9");
        cyc(1, 41, 1, 3, "R9");
        cfg_we = 1'b1; cfg_addr = pair_reg(0, 0); cfg_wdata = watch_val(0, 3);
        cyc(1, 3, 0, 0, "R9 disarm seen at next fetch");
        cfg_we = 1'b0;
        cyc(1, 4, 0, 0, "R9");
    endtask

    task automatic t_skip;
        cfg_wr(pair_reg(0, 0), watch_val(1, 0));
        restart("R10");
        cyc(0, 0, 0, 0, "R10 entry watched");
        cyc(1, 40, 0, 0, "R10 reset routine skipped");
        cfg_wr(pair_reg(0, 0), watch_val(0, 0));
    endtask

    task automatic t_ignored;
        patch_wr(59, 32'hFEED_0059);
        cfg_wr(pair_reg(4, 1), 32'(50));
        cfg_wr(pair_reg(4, 0), watch_val(1, 0));
        cfg_wr(pair_reg(31, 0), watch_val(1, 0));
        patch_wr(60, 32'hBAD0_0060);
        patch_wr(63, 32'hBAD0_0063);
        restart("R10");
        cyc(1, 0, 0, 0, "R11 pair index out of range");
        cyc(1, 1, 1, 1019, "R11");
        cyc(1, 1019, 0, 0, "R11 last patch word kept");
        cyc(1, 1020, 0, 0, "R11 beyond patch reads zero");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 60; i++) shadow[i] = 32'h0;
        t_reset;
        t_branch_wrap;
        t_redirect;
        t_priority;
        t_no_recheck;
        t_parity;
        t_timing;
        t_skip;
        t_ignored;
        repeat (2) @(negedge clk);
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run;
    end

endmodule